// File: doc/BRIEF.md
# Timer and Watchdog with Shared Prescaler

This block combines an 8-bit up-counter (the timer) and a watchdog counter that share one prescaler. A steering bit in the control register gives the prescaler to one of the two units. The other unit then counts its own input events one for one. The timer counts either an internal tick or edges seen on an asynchronous count pin. The internal tick is the block clock divided by 2 or by 4. Pin edges pass through a synchronizer first, and a control bit chooses rising or falling edges. When the timer wraps from all ones to zero it raises a sticky overflow flag.

The watchdog counts pulses from a free-running tick input. That input keeps arriving while the rest of the device sleeps. When the watchdog is enabled and reaches a parameterized number of counted events, it emits a one-cycle reset pulse. A clear strobe restarts it, and disabling it holds it at zero. Software reaches the block through a single write port. A two-bit target select picks the control register, the timer value or the flag. The timer value is always visible on an output.

Top module: `tmr_wdg_unit`

## Requirements
- R1: After reset the timer output is 0, the overflow flag is 0 and no watchdog reset pulse is present. The control register resets to: prescaler assigned to the watchdog, divide by 2, internal source, rising edge, ratio 0, watchdog off.
- R2: With `wr_sel_i`=1, a write loads the timer. Control bit 0 selects the internal tick: clock/2 when 0, clock/4 when 1. With control bit 3 = 1 (prescaler on the watchdog), the timer advances once per internal tick.
- R3: With control bit 3 = 0, ratio field n (control bits 6:4) makes the timer advance once per 2^(n+1) source ticks. A timer write or a change of bit 3 restarts the prescaler from zero.
- R4: With control bit 1 = 1, the timer counts the synchronized count pin. Control bit 2 = 0 counts rising edges and 1 counts falling edges. The opposite edge has no effect.
- R5: An increment from the all-ones value to 0 sets the overflow flag. The flag stays set while the timer keeps counting.
- R6: A write with `wr_sel_i`=2 and data bit 0 = 0 clears the flag. The same write with data bit 0 = 1 leaves the flag unchanged.
- R7: With control bit 7 = 1 and bit 3 = 0, the watchdog emits a one-cycle `wdg_rst_o` pulse on the `WDG_LIMIT`-th tick and restarts from zero.
- R8: With control bit 3 = 1, the watchdog counts once per 2^n ticks, where n is the ratio field.
- R9: A `wdg_clr_i` strobe restarts the watchdog count. When the prescaler is assigned to the watchdog, the strobe also clears the prescaler.
- R10: With control bit 7 = 0, the watchdog never emits a reset and its count is held at zero.
- R11: While `sleep_i`=1 the internal tick stops, so the timer holds in internal mode, but the watchdog keeps counting and can still time out.
- R12: `wr_sel_i`=0 writes the control register and `wr_sel_i`=3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (oscillator) |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Sleep state; stops the internal tick |
| ext_pin_i | input | 1 | Asynchronous external count pin |
| wdg_tick_i | input | 1 | Free-running watchdog tick, one-cycle pulses |
| wdg_clr_i | input | 1 | Watchdog restart strobe |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target: 0 control, 1 timer, 2 flag, 3 none |
| wr_data_i | input | TMR_W | Write data |
| tmr_o | output | TMR_W | Current timer value |
| ovf_o | output | 1 | Sticky overflow flag |
| wdg_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
The assertions assume the following about the inputs:
- The tick input arrives as single-cycle pulses that are synchronous to the block clock.
- The write select takes only its four defined codes.
- The count pin stays at each level for several clock cycles, so the synchronizer sees every edge.

The stimulus drives every input on the falling clock edge. It makes tick and clear strobes one cycle wide and holds each pin level for six cycles. It measures timer windows in whole periods of the selected tick. The result therefore does not depend on the phase of the free-running divider.

// File: rtl/tmr_wdg_pkg.sv
package tmr_wdg_pkg;
   localparam int RATIO_W = 3;
   localparam int PSC_W   = 1 << RATIO_W;
   localparam int CTRL_W  = 8;

   typedef struct packed {
      logic               wdg_en;
      logic [RATIO_W-1:0] ratio;
      logic               psc_to_wdg;
      logic               edge_fall;
      logic               src_ext;
      logic               clk_div4;
   } ctrl_t;

   localparam ctrl_t CTRL_RST = '{wdg_en: 1'b0, ratio: '0, psc_to_wdg: 1'b1,
                                  edge_fall: 1'b0, src_ext: 1'b0, clk_div4: 1'b0};

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_TMR  = 2'd1,
      SEL_FLAG = 2'd2,
      SEL_NONE = 2'd3
   } wr_sel_e;
endpackage

// File: rtl/tmr_clk_src.sv
module tmr_clk_src #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_i,
   input  logic clk_div4_i,
   input  logic src_ext_i,
   input  logic edge_fall_i,
   input  logic ext_pin_i,
   output logic src_tick_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $fatal(1, "SYNC_STAGES must be at least 2");
   end

   logic [1:0]           div_q;
   logic [SYNC_STAGES:0] pin_q;   // top bit holds the previous synchronized level
   logic                 inst_tick, pin_now, pin_old, ext_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        div_q <= '0;
      else if (!sleep_i) div_q <= div_q + 1'b1;
   end

   assign inst_tick = !sleep_i && (clk_div4_i ? (div_q == 2'b11) : div_q[0]);

   for (genvar i = 0; i <= SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pin_q[0] <= 1'b0;
            else        pin_q[0] <= ext_pin_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pin_q[i] <= 1'b0;
            else        pin_q[i] <= pin_q[i-1];
         end
      end
   end

   assign pin_now    = pin_q[SYNC_STAGES-1];
   assign pin_old    = pin_q[SYNC_STAGES];
   assign ext_tick   = edge_fall_i ? (!pin_now && pin_old) : (pin_now && !pin_old);
   assign src_tick_o = src_ext_i ? ext_tick : inst_tick;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int W     = 8,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             tick_i,
   input  logic             to_wdg_i,
   input  logic [SEL_W-1:0] ratio_i,
   output logic             tick_o
);
   if (W != (1 << SEL_W)) begin : g_bad_w
      $fatal(1, "prescaler width must equal 2**SEL_W");
   end

   logic [W-1:0] cnt_q;
   logic [W:0]   taps;    // taps[k]: the low k bits of the count are all ones
   logic [SEL_W:0] k_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
   end

   assign taps[0] = 1'b1;
   for (genvar k = 1; k <= W; k++) begin : g_tap
      assign taps[k] = &cnt_q[k-1:0];
   end

   // watchdog side divides by 2^n, timer side by 2^(n+1)
   assign k_sel  = to_wdg_i ? {1'b0, ratio_i} : ({1'b0, ratio_i} + 1'b1);
   assign tick_o = tick_i && taps[k_sel];
endmodule

// File: rtl/tmr_wdg_core.sv
module tmr_wdg_core #(
   parameter int LIMIT = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic clr_i,
   input  logic tick_i,
   output logic rst_o
);
   localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;

   if (LIMIT < 2) begin : g_bad_limit
      $fatal(1, "watchdog LIMIT must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rst_o <= 1'b0;
      end else begin
         rst_o <= 1'b0;
         if (clr_i || !en_i) begin
            cnt_q <= '0;
         end else if (tick_i) begin
            if (cnt_q == CNT_W'(LIMIT - 1)) begin
               cnt_q <= '0;
               rst_o <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/tmr_wdg_unit.sv
module tmr_wdg_unit
   import tmr_wdg_pkg::*;
#(
   parameter int TMR_W       = 8,
   parameter int WDG_LIMIT   = 20,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep_i,
   input  logic             ext_pin_i,
   input  logic             wdg_tick_i,
   input  logic             wdg_clr_i,
   input  logic             wr_en_i,
   input  logic [1:0]       wr_sel_i,
   input  logic [TMR_W-1:0] wr_data_i,
   output logic [TMR_W-1:0] tmr_o,
   output logic             ovf_o,
   output logic             wdg_rst_o
);
   if (TMR_W < CTRL_W) begin : g_bad_tmr_w
      $fatal(1, "TMR_W must cover the control register width");
   end

   ctrl_t ctrl_q, ctrl_d;
   logic  wr_ctrl, wr_tmr, wr_flag;
   logic  src_tick, psc_in, psc_out, psc_clr, tmr_inc, wdg_inc;
   logic  wdg_en;

   assign ctrl_d  = ctrl_t'(wr_data_i[CTRL_W-1:0]);
   assign wr_ctrl = wr_en_i && (wr_sel_i == SEL_CTRL);
   assign wr_tmr  = wr_en_i && (wr_sel_i == SEL_TMR);
   assign wr_flag = wr_en_i && (wr_sel_i == SEL_FLAG);
   assign wdg_en  = ctrl_q.wdg_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= CTRL_RST;
      else if (wr_ctrl) ctrl_q <= ctrl_d;
   end

   tmr_clk_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
      .clk        (clk),
      .rst_n      (rst_n),
      .sleep_i    (sleep_i),
      .clk_div4_i (ctrl_q.clk_div4),
      .src_ext_i  (ctrl_q.src_ext),
      .edge_fall_i(ctrl_q.edge_fall),
      .ext_pin_i  (ext_pin_i),
      .src_tick_o (src_tick)
   );

   assign psc_in  = ctrl_q.psc_to_wdg ? wdg_tick_i : src_tick;
   assign psc_clr = wr_tmr
                 || (wr_ctrl && (ctrl_d.psc_to_wdg != ctrl_q.psc_to_wdg))
                 || (wdg_clr_i && ctrl_q.psc_to_wdg);

   tmr_prescaler #(.W(PSC_W), .SEL_W(RATIO_W)) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (psc_clr),
      .tick_i  (psc_in),
      .to_wdg_i(ctrl_q.psc_to_wdg),
      .ratio_i (ctrl_q.ratio),
      .tick_o  (psc_out)
   );

   assign tmr_inc = ctrl_q.psc_to_wdg ? src_tick : psc_out;
   assign wdg_inc = ctrl_q.psc_to_wdg ? psc_out : wdg_tick_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_o <= '0;
         ovf_o <= 1'b0;
      end else begin
         if (wr_tmr)       tmr_o <= wr_data_i;
         else if (tmr_inc) tmr_o <= tmr_o + 1'b1;

         if (!wr_tmr && tmr_inc && (&tmr_o)) ovf_o <= 1'b1;
         else if (wr_flag && !wr_data_i[0])  ovf_o <= 1'b0;
      end
   end

   tmr_wdg_core #(.LIMIT(WDG_LIMIT)) u_wdg (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (wdg_en),
      .clr_i (wdg_clr_i),
      .tick_i(wdg_inc),
      .rst_o (wdg_rst_o)
   );
endmodule

// File: rtl/tmr_wdg_chk.sv
module tmr_wdg_chk
   import tmr_wdg_pkg::*;
#(
   parameter int TMR_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sleep_i,
   input logic             wr_en_i,
   input logic [1:0]       wr_sel_i,
   input logic [TMR_W-1:0] wr_data_i,
   input logic [TMR_W-1:0] tmr_o,
   input logic             ovf_o,
   input logic             wdg_rst_o,
   input logic             wdg_en,
   input logic             src_ext
);
   logic tmr_write, flag_clear;
   assign tmr_write  = wr_en_i && (wr_sel_i == SEL_TMR);
   assign flag_clear = wr_en_i && (wr_sel_i == SEL_FLAG) && !wr_data_i[0];

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tmr_write |=> (tmr_o == $past(tmr_o)) || (tmr_o == TMR_W'($past(tmr_o) + 1'b1)));

   assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_o) |-> (tmr_o == '0));

   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !flag_clear) |=> ovf_o);

   assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wdg_rst_o |=> !wdg_rst_o);

   assert_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wdg_rst_o |-> $past(wdg_en));

   assert_sleep_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_i && !src_ext && !tmr_write) |=> $stable(tmr_o));
endmodule

bind tmr_wdg_unit tmr_wdg_chk #(.TMR_W(TMR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sleep_i  (sleep_i),
   .wr_en_i  (wr_en_i),
   .wr_sel_i (wr_sel_i),
   .wr_data_i(wr_data_i),
   .tmr_o    (tmr_o),
   .ovf_o    (ovf_o),
   .wdg_rst_o(wdg_rst_o),
   .wdg_en   (wdg_en),
   .src_ext  (ctrl_q.src_ext)
);

// File: tb/test_tmr_wdg_unit.sv
module test_tmr_wdg_unit;
   import tmr_wdg_pkg::*;

   localparam int TMR_W = 8;
   localparam int LIMIT = 20;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sleep_i = 1'b0;
   logic             ext_pin_i = 1'b0;
   logic             wdg_tick_i = 1'b0;
   logic             wdg_clr_i = 1'b0;
   logic             wr_en_i = 1'b0;
   logic [1:0]       wr_sel_i = SEL_NONE;
   logic [TMR_W-1:0] wr_data_i = '0;
   logic [TMR_W-1:0] tmr_o;
   logic             ovf_o;
   logic             wdg_rst_o;

   always #10 clk = ~clk;   // 50 MHz

   tmr_wdg_unit #(.TMR_W(TMR_W), .WDG_LIMIT(LIMIT), .SYNC_STAGES(2)) i_tmr_wdg_unit (
      .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .ext_pin_i(ext_pin_i),
      .wdg_tick_i(wdg_tick_i), .wdg_clr_i(wdg_clr_i), .wr_en_i(wr_en_i),
      .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .tmr_o(tmr_o), .ovf_o(ovf_o),
      .wdg_rst_o(wdg_rst_o)
   );

   typedef struct {
      string            req;
      bit               use_t;
      logic [TMR_W-1:0] t;
      bit               use_f;
      logic             f;
      bit               use_r;
      int               r;
   } item_t;

   item_t sb_q[$];
   event  sample_ev;
   int    n_cmp = 0;
   int    n_bad = 0;
   int    rst_seen = 0;
   int    exp_rst = 0;
   bit    done = 1'b0;

   always @(negedge clk) if (rst_n && wdg_rst_o) rst_seen++;

   // monitor: pops expectations and compares against the outputs
   initial begin
      forever begin
         @(sample_ev);
         while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            if (it.use_t) begin
               n_cmp++;
               if (tmr_o !== it.t) begin
                  n_bad++;
                  $display("FAIL %s timer actual=%h expected=%h", it.req, tmr_o, it.t);
               end
            end
            if (it.use_f) begin
               n_cmp++;
               if (ovf_o !== it.f) begin
                  n_bad++;
                  $display("FAIL %s flag actual=%b expected=%b", it.req, ovf_o, it.f);
               end
            end
            if (it.use_r) begin
               n_cmp++;
               if (rst_seen != it.r) begin
                  n_bad++;
                  $display("FAIL %s reset pulses actual=%0d expected=%0d", it.req, rst_seen, it.r);
               end
            end
         end
      end
   end

   task automatic expect_now(input string req, input bit use_t, input logic [TMR_W-1:0] t,
                             input bit use_f, input logic f, input bit use_r, input int r);
      item_t it;
      #2;
      it.req = req; it.use_t = use_t; it.t = t;
      it.use_f = use_f; it.f = f; it.use_r = use_r; it.r = r;
      sb_q.push_back(it);
      -> sample_ev;
      #1;
   endtask

   task automatic write_reg(input logic [1:0] sel, input logic [TMR_W-1:0] data);
      @(negedge clk);
      wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
      @(negedge clk);
      wr_en_i = 1'b0; wr_sel_i = SEL_NONE;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_wdg(input int n);
      repeat (n) begin
         @(negedge clk); wdg_tick_i = 1'b1;
         @(negedge clk); wdg_tick_i = 1'b0;
      end
   endtask

   task automatic pin_level(input logic v);
      @(negedge clk); ext_pin_i = v;
      wait_cyc(6);
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog run did not finish actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      wait_cyc(3);
      expect_now("R1", 1, 8'h00, 1, 1'b0, 1, 0);
      @(negedge clk); rst_n = 1'b1;
      wait_cyc(2);
      expect_now("R1", 0, 8'h00, 1, 1'b0, 1, 0);

      // R2: clock/2, prescaler on the watchdog
      write_reg(SEL_CTRL, 8'h08);
      write_reg(SEL_TMR, 8'h20);
      wait_cyc(40);
      expect_now("R2", 1, 8'h34, 0, 1'b0, 0, 0);
      // R2: clock/4
      write_reg(SEL_CTRL, 8'h09);
      write_reg(SEL_TMR, 8'h50);
      wait_cyc(40);
      expect_now("R2", 1, 8'h5A, 0, 1'b0, 0, 0);

      // R3: prescaler on the timer, ratio 1 -> /4, clock/4
      write_reg(SEL_CTRL, 8'h11);
      write_reg(SEL_TMR, 8'h10);
      wait_cyc(64);
      expect_now("R3", 1, 8'h14, 0, 1'b0, 0, 0);
      // R3: ratio 0 -> /2, clock/2
      write_reg(SEL_CTRL, 8'h00);
      write_reg(SEL_TMR, 8'h00);
      wait_cyc(40);
      expect_now("R3", 1, 8'h0A, 0, 1'b0, 0, 0);

      // R5: wrap sets the flag, flag stays set
      write_reg(SEL_CTRL, 8'h08);
      write_reg(SEL_TMR, 8'hFE);
      wait_cyc(4);
      expect_now("R5", 1, 8'h00, 1, 1'b1, 0, 0);
      wait_cyc(2);
      expect_now("R5", 1, 8'h01, 1, 1'b1, 0, 0);

      // R6: write of 1 ignored, write of 0 clears
      write_reg(SEL_FLAG, 8'h01);
      expect_now("R6", 0, 8'h00, 1, 1'b1, 0, 0);
      write_reg(SEL_FLAG, 8'h00);
      expect_now("R6", 0, 8'h00, 1, 1'b0, 0, 0);

      // R12: external mode freezes the timer; select 3 writes nothing
      write_reg(SEL_CTRL, 8'h0A);
      write_reg(SEL_TMR, 8'h33);
      write_reg(SEL_NONE, 8'h99);
      wait_cyc(2);
      expect_now("R12", 1, 8'h33, 1, 1'b0, 0, 0);

      // R4: rising edges counted, falling ignored, then the reverse
      pin_level(1'b1);
      expect_now("R4", 1, 8'h34, 0, 1'b0, 0, 0);
      pin_level(1'b0);
      expect_now("R4", 1, 8'h34, 0, 1'b0, 0, 0);
      write_reg(SEL_CTRL, 8'h0E);
      pin_level(1'b1);
      expect_now("R4", 1, 8'h34, 0, 1'b0, 0, 0);
      pin_level(1'b0);
      expect_now("R4", 1, 8'h35, 0, 1'b0, 0, 0);

      // R10: watchdog disabled never fires
      write_reg(SEL_CTRL, 8'h08);
      pulse_wdg(30);
      wait_cyc(2);
      expect_now("R10", 0, 8'h00, 0, 1'b0, 1, exp_rst);

      // R11: sleep halts the timer, watchdog still times out (R8 ratio 0 = 1:1)
      write_reg(SEL_CTRL, 8'h88);
      @(negedge clk); sleep_i = 1'b1;
      write_reg(SEL_TMR, 8'h40);
      pulse_wdg(LIMIT);
      wait_cyc(2);
      exp_rst++;
      expect_now("R11", 1, 8'h40, 0, 1'b0, 1, exp_rst);
      @(negedge clk); sleep_i = 1'b0;

      // R7: watchdog 1:1 with prescaler on the timer
      write_reg(SEL_CTRL, 8'h80);
      pulse_wdg(LIMIT - 1);
      wait_cyc(2);
      expect_now("R7", 0, 8'h00, 0, 1'b0, 1, exp_rst);
      pulse_wdg(1);
      wait_cyc(2);
      exp_rst++;
      expect_now("R7", 0, 8'h00, 0, 1'b0, 1, exp_rst);

      // R9: clear strobe restarts the count
      pulse_wdg(15);
      @(negedge clk); wdg_clr_i = 1'b1;
      @(negedge clk); wdg_clr_i = 1'b0;
      pulse_wdg(15);
      wait_cyc(2);
      expect_now("R9", 0, 8'h00, 0, 1'b0, 1, exp_rst);
      pulse_wdg(LIMIT - 15);
      wait_cyc(2);
      exp_rst++;
      expect_now("R9", 0, 8'h00, 0, 1'b0, 1, exp_rst);

      // R8: prescaler on the watchdog, ratio 2 -> /4
      write_reg(SEL_CTRL, 8'hA8);
      pulse_wdg(4 * LIMIT - 1);
      wait_cyc(2);
      expect_now("R8", 0, 8'h00, 0, 1'b0, 1, exp_rst);
      pulse_wdg(1);
      wait_cyc(2);
      exp_rst++;
      expect_now("R8", 0, 8'h00, 0, 1'b0, 1, exp_rst);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule